// File: doc/BRIEF.md
# USB Host Bus State Sequencer

This block sequences the bus state of a full-speed USB host port. Software writes one of four functional states into a small register port: reset, resume, operational or suspend. The block then drives the line accordingly. In reset it holds SE0 on the bus. In resume it holds the K state, and on leaving resume it adds a short SE0 end-of-resume. In operational it counts bit times and raises a start-of-frame request once per frame, together with a 16-bit frame number. In suspend it leaves the line undriven and watches it for a remote wake-up K state.

Every timing decision is made on a 12 MHz bit-rate tick supplied from outside, so one tick is one bit time. A requested state is latched at once but applied only on the next tick. The block never changes state on its own: a detected wake-up only sets a sticky flag, which can raise an interrupt.

Top module: `usbh_bus_seq`

## Requirements
- R1: After hardware reset the applied state is reset (code 00). A read at address 0 returns the applied state in bits [1:0], encoded as 00 reset, 01 resume, 10 operational, 11 suspend. The frame number is 0 and the interrupt is low.
- R2: A write at address 0 of a value that differs from the applied state is applied on the next bit tick and not before. A write of the applied state's own value has no effect, including on frame timing.
- R3: While the applied state is reset, the outputs drive SE0 (drv_en=1, drv_dp=0, drv_dm=0) for as long as software keeps that state.
- R4: While the applied state is resume, the outputs drive K (drv_en=1, drv_dp=0, drv_dm=1).
- R5: Leaving resume drives SE0 for 2 bit ticks, counting the applying tick as the first, and then releases the line (drv_en=0) unless the new state drives. Leaving reset for a non-driving state releases the line from the applying tick on.
- R6: In operational, sof_req pulses for one clock every FRAME_BITS bit ticks. The first pulse comes on the FRAME_BITS-th tick after the tick that entered operational.
- R7: frame_num increments by one, modulo 2^16, in the same cycle as each sof_req pulse.
- R8: sof_req is never raised outside operational. A tick on which a change away from operational takes effect issues no SOF, even at a frame boundary.
- R9: In suspend, a K line state (line_k=1, line_j=0, line_se0=0) sampled on 2 consecutive bit ticks sets a sticky wake flag, read at address 1 bit 0. Writing 1 to address 1 bit 0 clears the flag, and a set in the same cycle wins over the clear.
- R10: wake_irq equals the wake flag AND the enable bit at address 1 bit 1. K states outside suspend do not set the flag, and the applied state does not change on wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-clock strobe per bit time (12 MHz) |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 state, 1 wake control |
| cfg_wdata | input | 2 | Register write data |
| cfg_rdata | output | 2 | Read data of the selected register |
| line_j | input | 1 | Line is in the J state |
| line_k | input | 1 | Line is in the K state |
| line_se0 | input | 1 | Line is in SE0 |
| drv_en | output | 1 | Line driver enable |
| drv_dp | output | 1 | Driven D+ value |
| drv_dm | output | 1 | Driven D- value |
| sof_req | output | 1 | Start-of-frame token request pulse |
| frame_num | output | 16 | Current frame number |
| wake_irq | output | 1 | Remote wake-up interrupt |

## Verification
Two functions can fall on the same bit tick: a state change away from operational, and the end of a frame interval that would otherwise issue an SOF. The bench provokes this by entering operational, counting exactly FRAME_BITS-1 ticks, and then writing suspend so that the change lands on the boundary tick. It judges the result by seeing no SOF pulse, an unchanged frame number and a read-back of suspend.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    ST_RESET  = 2'b00,
    ST_RESUME = 2'b01,
    ST_OPER   = 2'b10,
    ST_SUSP   = 2'b11
  } bus_st_e;

  typedef struct packed {
    logic en;
    logic dp;
    logic dm;
  } line_drv_t;

  localparam line_drv_t DRV_IDLE = '{en: 1'b0, dp: 1'b0, dm: 1'b0};
  localparam line_drv_t DRV_SE0  = '{en: 1'b1, dp: 1'b0, dm: 1'b0};
  localparam line_drv_t DRV_K    = '{en: 1'b1, dp: 1'b0, dm: 1'b1};

  // Drive pattern a steady state asks for, before any end-of-resume override
  function automatic line_drv_t state_drive(input bus_st_e st);
    case (st)
      ST_RESET:  state_drive = DRV_SE0;
      ST_RESUME: state_drive = DRV_K;
      default:   state_drive = DRV_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/bseq_cmd.sv
module bseq_cmd
  import bseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       cfg_wr,
  input  logic       cfg_addr,
  input  logic [1:0] cfg_wdata,
  output bus_st_e    state,
  output bus_st_e    next_state,
  output logic       apply_evt,
  output logic       wake_ie,
  output logic       wake_clr
);

  logic    pend;
  bus_st_e pend_val;
  logic    wr_state;
  logic    wr_change;

  assign wr_state   = cfg_wr && !cfg_addr;
  assign wr_change  = wr_state && (bus_st_e'(cfg_wdata) != state);
  assign apply_evt  = bit_tick && pend;
  assign next_state = apply_evt ? pend_val : state;
  assign wake_clr   = cfg_wr && cfg_addr && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RESET;
      pend     <= 1'b0;
      pend_val <= ST_RESET;
      wake_ie  <= 1'b0;
    end else begin
      if (apply_evt) begin
        state <= pend_val;
        pend  <= 1'b0;
      end
      if (wr_change) begin
        pend     <= 1'b1;
        pend_val <= bus_st_e'(cfg_wdata);
      end
      if (cfg_wr && cfg_addr) begin
        wake_ie <= cfg_wdata[1];
      end
    end
  end

endmodule

// File: rtl/bseq_frame.sv
module bseq_frame
  import bseq_pkg::*;
#(
  parameter int FRAME_BITS = 12000,
  parameter int FN_W       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  bus_st_e         state,
  input  bus_st_e         next_state,
  input  logic            apply_evt,
  output logic            sof_req,
  output logic [FN_W-1:0] frame_num,
  output logic            frame_end
);

  localparam int CW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] bit_cnt;
  logic          entering;

  function automatic logic [FN_W-1:0] fn_inc(input logic [FN_W-1:0] v);
    fn_inc = v + FN_W'(1);
  endfunction

  assign entering  = apply_evt && (next_state == ST_OPER);
  assign frame_end = bit_tick && (state == ST_OPER) && (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      sof_req   <= 1'b0;
      frame_num <= '0;
    end else begin
      sof_req <= 1'b0;
      if (entering) begin
        bit_cnt <= '0;
      end else if (bit_tick && state == ST_OPER) begin
        if (frame_end) begin
          bit_cnt <= '0;
          if (next_state == ST_OPER) begin
            sof_req   <= 1'b1;
            frame_num <= fn_inc(frame_num);
          end
        end else begin
          bit_cnt <= bit_cnt + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/bseq_wake.sv
module bseq_wake
  import bseq_pkg::*;
#(
  parameter int WAKE_BITS = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bit_tick,
  input  bus_st_e state,
  input  logic    line_j,
  input  logic    line_k,
  input  logic    line_se0,
  input  logic    wake_clr,
  output logic    wake_flag,
  output logic    wake_set
);

  localparam int RW = $clog2(WAKE_BITS + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(WAKE_BITS);

  logic [RW-1:0] run;
  logic          k_seen;

  function automatic logic [RW-1:0] sat_inc(input logic [RW-1:0] v);
    sat_inc = (v == RUN_MAX) ? v : v + RW'(1);
  endfunction

  assign k_seen   = line_k && !line_j && !line_se0;
  assign wake_set = bit_tick && (state == ST_SUSP) && k_seen
                    && (sat_inc(run) == RUN_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= '0;
      wake_flag <= 1'b0;
    end else begin
      if (state != ST_SUSP) begin
        run <= '0;
      end else if (bit_tick) begin
        run <= k_seen ? sat_inc(run) : '0;
      end
      if (wake_set) begin
        wake_flag <= 1'b1;
      end else if (wake_clr) begin
        wake_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bseq_drive.sv
module bseq_drive
  import bseq_pkg::*;
#(
  parameter int EOR_BITS = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_tick,
  input  bus_st_e   state,
  input  logic      apply_evt,
  output line_drv_t drv,
  output logic      eor_busy
);

  localparam int EW = $clog2(EOR_BITS + 1);

  logic [EW-1:0] eor_cnt;

  assign eor_busy = (eor_cnt != '0);
  assign drv      = eor_busy ? DRV_SE0 : state_drive(state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eor_cnt <= '0;
    end else if (apply_evt && state == ST_RESUME) begin
      eor_cnt <= EW'(EOR_BITS);
    end else if (bit_tick && eor_busy) begin
      eor_cnt <= eor_cnt - EW'(1);
    end
  end

endmodule

// File: rtl/usbh_bus_seq.sv
module usbh_bus_seq
  import bseq_pkg::*;
#(
  parameter int FRAME_BITS = 12000,
  parameter int FN_W       = 16,
  parameter int WAKE_BITS  = 2,
  parameter int EOR_BITS   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic            cfg_wr,
  input  logic            cfg_addr,
  input  logic [1:0]      cfg_wdata,
  output logic [1:0]      cfg_rdata,
  input  logic            line_j,
  input  logic            line_k,
  input  logic            line_se0,
  output logic            drv_en,
  output logic            drv_dp,
  output logic            drv_dm,
  output logic            sof_req,
  output logic [FN_W-1:0] frame_num,
  output logic            wake_irq
);

  bus_st_e   state;
  bus_st_e   next_state;
  logic      apply_evt;
  logic      wake_ie;
  logic      wake_clr;
  logic      wake_flag;
  logic      wake_set;
  logic      frame_end;
  logic      eor_busy;
  line_drv_t drv;

  bseq_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .state(state), .next_state(next_state), .apply_evt(apply_evt),
    .wake_ie(wake_ie), .wake_clr(wake_clr)
  );

  bseq_frame #(.FRAME_BITS(FRAME_BITS), .FN_W(FN_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .state(state), .next_state(next_state), .apply_evt(apply_evt),
    .sof_req(sof_req), .frame_num(frame_num), .frame_end(frame_end)
  );

  bseq_wake #(.WAKE_BITS(WAKE_BITS)) u_wake (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .state(state),
    .line_j(line_j), .line_k(line_k), .line_se0(line_se0),
    .wake_clr(wake_clr), .wake_flag(wake_flag), .wake_set(wake_set)
  );

  bseq_drive #(.EOR_BITS(EOR_BITS)) u_drive (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .state(state), .apply_evt(apply_evt),
    .drv(drv), .eor_busy(eor_busy)
  );

  assign drv_en    = drv.en;
  assign drv_dp    = drv.dp;
  assign drv_dm    = drv.dm;
  assign wake_irq  = wake_flag && wake_ie;
  assign cfg_rdata = cfg_addr ? {wake_ie, wake_flag} : state;

endmodule

// File: rtl/usbh_bus_seq_chk.sv
module usbh_bus_seq_chk
  import bseq_pkg::*;
#(
  parameter int FN_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bit_tick,
  input bus_st_e         state,
  input logic            sof_req,
  input logic [FN_W-1:0] frame_num,
  input logic            drv_en,
  input logic            drv_dp,
  input logic            drv_dm,
  input logic            eor_busy,
  input logic            wake_flag,
  input logic            wake_clr,
  input logic            wake_set,
  input logic            wake_ie,
  input logic            wake_irq
);

  p_state_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state) |-> $past(bit_tick));

  p_reset_se0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESET) |-> (drv_en && !drv_dp && !drv_dm));

  p_resume_k_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESUME && !eor_busy) |-> (drv_en && !drv_dp && drv_dm));

  p_eor_se0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eor_busy |-> (drv_en && !drv_dp && !drv_dm));

  p_sof_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sof_req |=> !sof_req);

  p_frame_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_req |-> (frame_num == FN_W'($past(frame_num) + 1'b1)));

  p_no_sof_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sof_req |-> (state == ST_OPER));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && !wake_clr) |=> wake_flag);

  p_set_only_suspend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_set |-> (state == ST_SUSP));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (wake_flag && wake_ie));

endmodule

bind usbh_bus_seq usbh_bus_seq_chk #(.FN_W(FN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .state(state),
  .sof_req(sof_req), .frame_num(frame_num),
  .drv_en(drv_en), .drv_dp(drv_dp), .drv_dm(drv_dm), .eor_busy(eor_busy),
  .wake_flag(wake_flag), .wake_clr(wake_clr), .wake_set(wake_set),
  .wake_ie(wake_ie), .wake_irq(wake_irq)
);

// File: tb/usbh_bus_seq_tb.sv
`timescale 1ns/100ps
module usbh_bus_seq_tb;

  localparam int FRAME = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [1:0]  cfg_wdata = '0;
  logic [1:0]  cfg_rdata;
  logic        line_j = 1'b1;
  logic        line_k = 1'b0;
  logic        line_se0 = 1'b0;
  logic        drv_en, drv_dp, drv_dm, sof_req, wake_irq;
  logic [15:0] frame_num;

  int checks = 0;
  int errors = 0;
  int sof_cnt = 0;
  int sof_mark;
  logic [15:0] fn_exp = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usbh_bus_seq #(.FRAME_BITS(FRAME)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .line_j(line_j), .line_k(line_k),
    .line_se0(line_se0), .drv_en(drv_en), .drv_dp(drv_dp),
    .drv_dm(drv_dm), .sof_req(sof_req), .frame_num(frame_num),
    .wake_irq(wake_irq)
  );

  always @(negedge clk) if (rst_n && sof_req) sof_cnt++;

  typedef struct packed {
    logic [1:0] st;
    logic [7:0] ticks;
    logic [2:0] drv;
    logic [3:0] sofs;
  } vec_t;

  // state, ticks after the applying tick, {en,dp,dm} after applying, SOFs
  localparam vec_t VECS [5] = '{
    '{st: 2'b10, ticks: 8'd45, drv: 3'b000, sofs: 4'd2},
    '{st: 2'b11, ticks: 8'd30, drv: 3'b000, sofs: 4'd0},
    '{st: 2'b01, ticks: 8'd5,  drv: 3'b101, sofs: 4'd0},
    '{st: 2'b00, ticks: 8'd5,  drv: 3'b100, sofs: 4'd0},
    '{st: 2'b10, ticks: 8'd25, drv: 3'b000, sofs: 4'd1}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic a, input logic [1:0] d);
    @(negedge clk) begin cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; end
    @(negedge clk) begin cfg_wr = 1'b0; cfg_addr = 1'b0; end
  endtask

  task automatic rd(input logic a, output logic [1:0] d);
    @(negedge clk) cfg_addr = a;
    #1 d = cfg_rdata;
    cfg_addr = 1'b0;
  endtask

  task automatic go(input logic [1:0] st);
    wr(1'b0, st);
    tick();
  endtask

  task automatic line_kstate(input bit k);
    line_j = !k;
    line_k = k;
  endtask

  logic [1:0] rv;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(1'b0, rv);
    check("R1", "state after reset", rv, 2'b00);
    check("R1", "frame number after reset", frame_num, 16'd0);
    check("R1", "irq after reset", wake_irq, 1'b0);
    check("R3", "drive in reset", {drv_en, drv_dp, drv_dm}, 3'b100);

    // Vector table walk
    foreach (VECS[v]) begin
      go(VECS[v].st);
      rd(1'b0, rv);
      check("R2", $sformatf("vec %0d applied state", v), rv, VECS[v].st);
      check("R4", $sformatf("vec %0d drive", v),
            {drv_en, drv_dp, drv_dm}, VECS[v].drv);
      sof_mark = sof_cnt;
      tick(VECS[v].ticks);
      check("R6", $sformatf("vec %0d SOF count", v),
            sof_cnt - sof_mark, VECS[v].sofs);
      fn_exp = fn_exp + 16'(VECS[v].sofs);
      check("R7", $sformatf("vec %0d frame number", v), frame_num, fn_exp);
    end

    // R2: pending write not applied before tick; same-value write no effect
    go(2'b11);
    wr(1'b0, 2'b10);
    rd(1'b0, rv);
    check("R2", "state before tick", rv, 2'b11);
    tick();
    sof_mark = sof_cnt;
    tick(10);
    wr(1'b0, 2'b10);
    tick(9);
    check("R2", "no SOF early after same-value write", sof_cnt - sof_mark, 0);
    tick();
    check("R6", "SOF on 20th tick", sof_cnt - sof_mark, 1);
    fn_exp++;
    check("R7", "frame number step", frame_num, fn_exp);

    // R8: leaving operational on the boundary tick
    go(2'b11);
    go(2'b10);
    sof_mark = sof_cnt;
    tick(FRAME - 1);
    wr(1'b0, 2'b11);
    tick();
    check("R8", "no SOF on leaving tick", sof_cnt - sof_mark, 0);
    check("R8", "frame number held", frame_num, fn_exp);
    rd(1'b0, rv);
    check("R8", "suspend applied", rv, 2'b11);
    sof_mark = sof_cnt;
    tick(30);
    check("R8", "no SOF in suspend", sof_cnt - sof_mark, 0);

    // R9/R10: wake detection in suspend
    wr(1'b1, 2'b10);
    line_kstate(1); tick();
    line_kstate(0); tick();
    rd(1'b1, rv);
    check("R9", "single K tick ignored", rv[0], 1'b0);
    line_kstate(1); tick(2);
    rd(1'b1, rv);
    check("R9", "flag after 2 K ticks", rv[0], 1'b1);
    check("R10", "irq enabled", wake_irq, 1'b1);
    line_kstate(0); tick(3);
    rd(1'b1, rv);
    check("R9", "flag sticky", rv[0], 1'b1);
    rd(1'b0, rv);
    check("R10", "no self state change", rv, 2'b11);
    wr(1'b1, 2'b11);
    rd(1'b1, rv);
    check("R9", "flag cleared", rv[0], 1'b0);
    check("R10", "irq cleared", wake_irq, 1'b0);
    wr(1'b1, 2'b00);
    line_kstate(1); tick(2);
    rd(1'b1, rv);
    check("R10", "flag set with irq masked", rv[0], 1'b1);
    check("R10", "irq masked", wake_irq, 1'b0);
    line_kstate(0);
    wr(1'b1, 2'b01);

    // R10: K outside suspend ignored
    go(2'b10);
    line_kstate(1); tick(3);
    line_kstate(0);
    rd(1'b1, rv);
    check("R10", "no flag in operational", rv[0], 1'b0);

    // R5: end-of-resume then release
    go(2'b01);
    check("R4", "resume K", {drv_en, drv_dp, drv_dm}, 3'b101);
    go(2'b10);
    check("R5", "EOR first bit", {drv_en, drv_dp, drv_dm}, 3'b100);
    tick();
    check("R5", "EOR second bit", {drv_en, drv_dp, drv_dm}, 3'b100);
    tick();
    check("R5", "released after EOR", drv_en, 1'b0);

    // R3/R5: reset held, then released on leaving
    go(2'b00);
    tick(7);
    check("R3", "reset SE0 held", {drv_en, drv_dp, drv_dm}, 3'b100);
    go(2'b11);
    check("R5", "released on leaving reset", drv_en, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule